// File: doc/BRIEF.md
# Complex DDC Sample Lane Framer

The block sits behind four digital down-converters. Two converter channels feed them, with two down-converters each. Each down-converter delivers one 16-bit in-phase sample and one 16-bit quadrature sample per frame period, at the converter sample rate divided by eight. The framer ties each down-converter to a lane of its own and turns its sample pair into a four-octet frame. That frame is sent one octet per octet clock, so the link looks downstream like eight virtual converters.

Along with the lane octets, the block marks the first octet of every frame. It also marks the first octet of every multiframe, which is K frames long. A down-converter that has no fresh pair at a frame boundary gets its last pair sent again, and a sticky flag records the underflow. A helper, combinational from its input, reports the lane rate that a given converter sample rate needs and flags any rate the lanes cannot carry.

Top module: `ddc_lane_framer`

## Requirements
- R1: Every lane frame is four octets, sent in this order: I high byte, I low byte, Q high byte, Q low byte.
- R2: Input pairs are sampled only on the octet clock that starts a frame. Input changes during octets 1 to 3 do not affect the frame in flight.
- R3: Down-converter n maps to lane n, with n = 0..3 meaning channel A first, channel A second, channel B first, channel B second. Sample n sits at bits [16n+15:16n] of the I and Q inputs. Lane n sits at bits [8n+7:8n] of the lane output.
- R4: `sof_o` is high exactly in the cycles that carry octet 0 of a frame, so it is high once every four cycles.
- R5: `somf_o` is high with `sof_o` on frame 0 after reset and on every K-th frame after that (K = 32 by default). It is low at all other times.
- R6: If `valid_i[n]` is low at a frame start, lane n sends its previous pair again. If no pair has been captured since reset, it sends zeros.
- R7: `underflow_o[n]` is set by a frame start that sees `valid_i[n]` low. It stays set until reset.
- R8: While `rst_ni` is low, all lane octets, `sof_o`, `somf_o` and `underflow_o` are zero. The first octet after reset is the I high byte of frame 0, with `sof_o` and `somf_o` high.
- R9: `lane_rate_mbps_o` equals 8 × 16 × 10/8 × (fs/8) / 4, which is 5 × `sample_rate_msps_i`, in Mb/s.
- R10: `rate_invalid_o` is high exactly when the required lane rate exceeds 12500 Mb/s, that is, when the sample rate is above 2500 MS/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Octet clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| i_data_i | input | 64 | In-phase samples, 16 bits per down-converter |
| q_data_i | input | 64 | Quadrature samples, 16 bits per down-converter |
| valid_i | input | 4 | Pair valid, one bit per down-converter |
| sample_rate_msps_i | input | 16 | Configured converter sample rate, MS/s |
| lane_data_o | output | 32 | One octet per lane |
| sof_o | output | 1 | First octet of frame |
| somf_o | output | 1 | First octet of multiframe |
| underflow_o | output | 4 | Sticky underflow flag, one bit per lane |
| lane_rate_mbps_o | output | 32 | Required lane rate, Mb/s |
| rate_invalid_o | output | 1 | Lane rate above the supported maximum |

## Verification
Inputs are first held for whole frames, with values that differ per lane and between I and Q. A swapped lane, a swapped component or a wrong byte order therefore shows up as a wrong octet. A second pattern changes the inputs on every octet clock, so any sampling outside the frame start corrupts octets 1 to 3. A third pattern drops valid bits at random, including whole frames with all lanes invalid, to check the repeat and sticky-flag paths. Sample rates of 2500, 2501 and 3000 MS/s bracket the lane-rate limit, and a reset in mid-multiframe checks that framing restarts at frame 0.

// File: rtl/ddc_framer_pkg.sv
`timescale 1ns/1ps
package ddc_framer_pkg;
  localparam int OCTET_W = 8;
  localparam int CODE_NUM = 10;  // line-code expansion numerator
  localparam int CODE_DEN = 8;
endpackage

// File: rtl/framer_timing.sv
`timescale 1ns/1ps
module framer_timing #(
  parameter int OCT_PER_FRAME = 4,
  parameter int FRAMES_PER_MF = 32,
  localparam int OCT_W = $clog2(OCT_PER_FRAME),
  localparam int FRM_W = $clog2(FRAMES_PER_MF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OCT_W-1:0] oct_idx_o,
  output logic             capture_o,
  output logic             sof_o,
  output logic             somf_o
);
  logic [OCT_W-1:0] oct_q;
  logic [FRM_W-1:0] frm_q;

  assign oct_idx_o = oct_q;
  assign capture_o = (oct_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oct_q  <= '0;
      frm_q  <= '0;
      sof_o  <= 1'b0;
      somf_o <= 1'b0;
    end else begin
      oct_q  <= (oct_q == OCT_W'(OCT_PER_FRAME - 1)) ? '0 : oct_q + 1'b1;
      sof_o  <= capture_o;
      somf_o <= capture_o && (frm_q == '0);
      if (capture_o)
        frm_q <= (frm_q == FRM_W'(FRAMES_PER_MF - 1)) ? '0 : frm_q + 1'b1;
    end
  end
endmodule

// File: rtl/framer_lane.sv
`timescale 1ns/1ps
module framer_lane
  import ddc_framer_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int OCT_W    = 2,
  localparam int PAIR_W  = 2 * SAMPLE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic [OCT_W-1:0]    oct_idx_i,
  input  logic [SAMPLE_W-1:0] i_smp_i,
  input  logic [SAMPLE_W-1:0] q_smp_i,
  input  logic                valid_i,
  output logic [OCTET_W-1:0]  octet_o,
  output logic                underflow_o
);
  logic [PAIR_W-1:0] pair_q, pair_nxt, pair_sh;

  // I occupies the upper half so it leaves first
  assign pair_nxt = valid_i ? {i_smp_i, q_smp_i} : pair_q;
  assign pair_sh  = pair_q << (OCTET_W * int'(oct_idx_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q      <= '0;
      octet_o     <= '0;
      underflow_o <= 1'b0;
    end else if (capture_i) begin
      pair_q  <= pair_nxt;
      octet_o <= pair_nxt[PAIR_W-1 -: OCTET_W];
      if (!valid_i) underflow_o <= 1'b1;
    end else begin
      octet_o <= pair_sh[PAIR_W-1 -: OCTET_W];
    end
  end
endmodule

// File: rtl/framer_rate_check.sv
`timescale 1ns/1ps
module framer_rate_check
  import ddc_framer_pkg::*;
#(
  parameter int NUM_LANES     = 4,
  parameter int SAMPLE_W      = 16,
  parameter int DECIM         = 8,
  parameter int SMP_PER_FRAME = 1,
  parameter int MAX_LANE_MBPS = 12500,
  parameter int FS_W          = 16,
  parameter int RATE_W        = 32,
  localparam int NUM_CONV     = 2 * NUM_LANES,
  localparam int RATE_NUM     = NUM_CONV * SAMPLE_W * SMP_PER_FRAME * CODE_NUM,
  localparam int RATE_DEN     = CODE_DEN * DECIM * NUM_LANES,
  localparam int PROD_W       = FS_W + 32
) (
  input  logic [FS_W-1:0]   fs_msps_i,
  output logic [RATE_W-1:0] lane_mbps_o,
  output logic              invalid_o
);
  logic [PROD_W-1:0] prod, quot;

  assign prod        = PROD_W'(fs_msps_i) * PROD_W'(RATE_NUM);
  assign quot        = prod / PROD_W'(RATE_DEN);
  assign lane_mbps_o = quot[RATE_W-1:0];
  assign invalid_o   = quot > PROD_W'(MAX_LANE_MBPS);
endmodule

// File: rtl/ddc_lane_framer.sv
`timescale 1ns/1ps
module ddc_lane_framer
  import ddc_framer_pkg::*;
#(
  parameter int NUM_LANES     = 4,
  parameter int SAMPLE_W      = 16,
  parameter int FRAMES_PER_MF = 32,
  parameter int DECIM         = 8,
  parameter int MAX_LANE_MBPS = 12500,
  parameter int FS_W          = 16,
  parameter int RATE_W        = 32,
  localparam int OCT_PER_FRAME = 2 * SAMPLE_W / OCTET_W,
  localparam int OCT_W         = $clog2(OCT_PER_FRAME)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_LANES*SAMPLE_W-1:0] i_data_i,
  input  logic [NUM_LANES*SAMPLE_W-1:0] q_data_i,
  input  logic [NUM_LANES-1:0]          valid_i,
  input  logic [FS_W-1:0]               sample_rate_msps_i,
  output logic [NUM_LANES*OCTET_W-1:0]  lane_data_o,
  output logic                          sof_o,
  output logic                          somf_o,
  output logic [NUM_LANES-1:0]          underflow_o,
  output logic [RATE_W-1:0]             lane_rate_mbps_o,
  output logic                          rate_invalid_o
);
  logic [OCT_W-1:0] oct_idx;
  logic             capture;

  framer_timing #(
    .OCT_PER_FRAME(OCT_PER_FRAME),
    .FRAMES_PER_MF(FRAMES_PER_MF)
  ) u_timing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .oct_idx_o (oct_idx),
    .capture_o (capture),
    .sof_o     (sof_o),
    .somf_o    (somf_o)
  );

  // fixed routing: converter n -> lane n
  for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
    framer_lane #(
      .SAMPLE_W(SAMPLE_W),
      .OCT_W   (OCT_W)
    ) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .capture_i   (capture),
      .oct_idx_i   (oct_idx),
      .i_smp_i     (i_data_i[n*SAMPLE_W +: SAMPLE_W]),
      .q_smp_i     (q_data_i[n*SAMPLE_W +: SAMPLE_W]),
      .valid_i     (valid_i[n]),
      .octet_o     (lane_data_o[n*OCTET_W +: OCTET_W]),
      .underflow_o (underflow_o[n])
    );
  end

  framer_rate_check #(
    .NUM_LANES    (NUM_LANES),
    .SAMPLE_W     (SAMPLE_W),
    .DECIM        (DECIM),
    .SMP_PER_FRAME(1),
    .MAX_LANE_MBPS(MAX_LANE_MBPS),
    .FS_W         (FS_W),
    .RATE_W       (RATE_W)
  ) u_rate (
    .fs_msps_i   (sample_rate_msps_i),
    .lane_mbps_o (lane_rate_mbps_o),
    .invalid_o   (rate_invalid_o)
  );
endmodule

// File: rtl/ddc_lane_framer_chk.sv
`timescale 1ns/1ps
module ddc_lane_framer_chk #(
  parameter int NUM_LANES     = 4,
  parameter int SAMPLE_W      = 16,
  parameter int DECIM         = 8,
  parameter int MAX_LANE_MBPS = 12500,
  parameter int FS_W          = 16,
  localparam int FS_LIMIT = MAX_LANE_MBPS * 8 * DECIM * NUM_LANES
                            / (2 * NUM_LANES * SAMPLE_W * 10)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sof_o,
  input logic                 somf_o,
  input logic [NUM_LANES-1:0] underflow_o,
  input logic [FS_W-1:0]      sample_rate_msps_i,
  input logic                 rate_invalid_o
);
  // R4: no back-to-back frame starts
  a_r4_sof_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);

  // R4: frame start recurs four cycles later
  a_r4_sof_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sof_o, 4) |-> sof_o);

  // R5: multiframe start only on a frame start
  a_r5_somf_in_sof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    somf_o |-> sof_o);

  // R7: flags never clear without reset
  a_r7_uf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((underflow_o & $past(underflow_o)) == $past(underflow_o)));

  // R7: a flag only rises with a frame start
  a_r7_uf_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((underflow_o & ~$past(underflow_o)) != '0) |-> sof_o);

  // R10: flag tracks the sample-rate limit
  a_r10_rate_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_invalid_o == (int'(sample_rate_msps_i) > FS_LIMIT));
endmodule

bind ddc_lane_framer ddc_lane_framer_chk #(
  .NUM_LANES    (NUM_LANES),
  .SAMPLE_W     (SAMPLE_W),
  .DECIM        (DECIM),
  .MAX_LANE_MBPS(MAX_LANE_MBPS),
  .FS_W         (FS_W)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .sof_o             (sof_o),
  .somf_o            (somf_o),
  .underflow_o       (underflow_o),
  .sample_rate_msps_i(sample_rate_msps_i),
  .rate_invalid_o    (rate_invalid_o)
);

// File: tb/ddc_lane_framer_tb.sv
`timescale 1ns/1ps
module ddc_lane_framer_tb;
  localparam int NL = 4;
  localparam int SW = 16;
  localparam int K  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NL*SW-1:0] i_d = '0, q_d = '0;
  logic [NL-1:0]    vld = '0;
  logic [15:0]      fs = 16'd1000;
  logic [NL*8-1:0]  lane;
  logic             sof, somf, inv;
  logic [NL-1:0]    uf;
  logic [31:0]      rate;

  ddc_lane_framer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .i_data_i(i_d), .q_data_i(q_d),
    .valid_i(vld), .sample_rate_msps_i(fs), .lane_data_o(lane),
    .sof_o(sof), .somf_o(somf), .underflow_o(uf),
    .lane_rate_mbps_o(rate), .rate_invalid_o(inv)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // behavioural reference
  int pos, frm;
  logic [31:0] held [NL];
  logic [7:0]  e_oct [NL];
  logic        e_sof, e_somf;
  logic [NL-1:0] e_uf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos = 0; frm = 0; e_sof = 0; e_somf = 0; e_uf = '0;
      for (int l = 0; l < NL; l++) begin held[l] = '0; e_oct[l] = '0; end
    end else begin
      if (pos == 0) begin
        e_sof = 1; e_somf = (frm == 0); frm = (frm + 1) % K;
        for (int l = 0; l < NL; l++) begin
          if (vld[l]) held[l] = {i_d[l*SW +: SW], q_d[l*SW +: SW]};
          else e_uf[l] = 1'b1;
        end
      end else begin
        e_sof = 0; e_somf = 0;
      end
      for (int l = 0; l < NL; l++) e_oct[l] = held[l][31 - 8*pos -: 8];
      pos = (pos + 1) % 4;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    for (int l = 0; l < NL; l++)
      chk($sformatf("R1 R2 R3 R6 lane%0d octet", l), 32'(lane[l*8 +: 8]), 32'(e_oct[l]));
    chk("R4 sof", 32'(sof), 32'(e_sof));
    chk("R5 somf", 32'(somf), 32'(e_somf));
    chk("R7 underflow", 32'(uf), 32'(e_uf));
    chk("R9 lane rate", rate, 32'(5 * int'(fs)));
    chk("R10 rate invalid", 32'(inv), 32'((5 * int'(fs)) > 12500));
    if (!rst_n) chk("R8 reset outputs", {lane[27:0], sof, somf, |uf, 1'b0}, 32'd0);
  endtask

  task automatic step(input logic [NL*SW-1:0] ni, input logic [NL*SW-1:0] nq,
                      input logic [NL-1:0] nv);
    @(negedge clk);
    compare();
    i_d = ni; q_d = nq; vld = nv;
  endtask

  function automatic logic [NL*SW-1:0] pat(input int f, input int iq);
    logic [NL*SW-1:0] v;
    for (int l = 0; l < NL; l++)
      v[l*SW +: SW] = {4'(l), 4'(iq ? 4'hC : 4'hA), 8'(f)};
    return v;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step('0, '0, '1);
    // R8: first frame from the inputs present at release
    i_d = pat(0, 0); q_d = pat(0, 1); vld = '1;
    @(negedge clk); rst_n = 1'b1;
    // frame-aligned distinct values
    for (int f = 1; f < 80; f++)
      for (int c = 0; c < 4; c++) step(pat(f, 0), pat(f, 1), '1);
    fs = 16'd2500;
    // inputs change every octet clock
    for (int c = 0; c < 200; c++)
      step({$urandom, $urandom}, {$urandom, $urandom}, '1);
    fs = 16'd2501;
    // random valid drops, then whole frames invalid
    for (int c = 0; c < 200; c++)
      step({$urandom, $urandom}, {$urandom, $urandom}, 4'($urandom));
    fs = 16'd3000;
    for (int c = 0; c < 16; c++)
      step({$urandom, $urandom}, {$urandom, $urandom}, '0);
    // reset mid-multiframe
    @(negedge clk); compare(); rst_n = 1'b0;
    step('0, '0, '1);
    step(pat(7, 0), pat(7, 1), '1);
    @(negedge clk); compare(); rst_n = 1'b1;
    fs = 16'd0;
    for (int c = 0; c < 300; c++)
      step({$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 5 == 0) ? 4'b0101 : '1);
    fs = 16'hFFFF;
    repeat (8) step('0, '0, '1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule